// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block drives the control pins of an external memory from microcode. Patterns of 32-bit words sit in an internal 64-entry pattern store, which the host loads through a simple write port. A granted request picks a start index. The sequencer then plays one word per clock cycle onto the chip-select, strobe and address-multiplex outputs. It stops after the word that carries the last flag.

Three kinds of request can start a pattern:
- A refresh request.
- A bus transfer. Its direction, size and alignment select one of four fixed entry points and a repeat count.
- A software run command. It is raised by a write hit while the mode opcode is 2'b11, and it starts at a host-given index.

A bus transfer that does not fit the burst form is replayed as back-to-back single-beat passes. Transfer acknowledges are produced only for bus transfers.

Top module: `pattern_sequencer`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_cs`, `mem_strobe`, `addr_mux`, `addr_latch` and `xfer_ack` are all zero.
- R2: A pattern word holds the last flag in bit 31, the acknowledge flag in bit 30, the address-multiplex field in bits 29:28, the strobes in bits 27:8 and the chip selects in bits 7:0. While `busy` is high, one word is shown per cycle on the outputs, starting at the entry index and ending with the word whose last flag is set. The first word appears two cycles after the clock edge that samples the request.
- R3: A bus pass starts at a fixed index: 0 for a single-beat read, 8 for a single-beat write, 16 for a burst read and 24 for a burst write. A refresh starts at index 48.
- R4: A bus transfer uses the burst form only when all of these hold: `burst_inh` is low, `xfer_addr` is 0 (32-byte aligned), and `xfer_size` is a non-zero multiple of 32. The burst pattern then runs `xfer_size`/32 times back to back.
- R5: When `burst_inh` is high, every bus transfer is done as single-beat passes.
- R6: A transfer that is not in burst form runs the single-beat pattern ceil(`xfer_size`/4) times back to back, and at least once.
- R7: A software run starts when `wr_hit` is high while `mode_op` is 2'b11. It begins at `mode_start`. A `wr_hit` under any other opcode starts nothing.
- R8: `xfer_ack` is high during a shown word with its acknowledge flag set, and only when that word belongs to a bus transfer. It stays low in software runs and refreshes.
- R9: Requests are held pending until the sequencer is idle. They are served with refresh first, then bus transfer, then software run.
- R10: `addr_latch` pulses for one cycle when the address-multiplex field differs from that of the previous word of the same pass.
- R11: A host write to the pattern store takes effect only while `busy` is low. A write made while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_we | input | 1 | Pattern store write strobe |
| ram_waddr | input | 6 | Pattern store write index |
| ram_wdata | input | 32 | Pattern word to store |
| mode_op | input | 2 | Mode opcode; 2'b11 arms a software run |
| mode_start | input | 6 | Start index for a software run |
| wr_hit | input | 1 | A write hit the region owned by this sequencer |
| bus_req | input | 1 | Bus transfer request pulse |
| bus_wr | input | 1 | Transfer direction, 1 = write |
| burst_inh | input | 1 | Forces single-beat passes |
| xfer_addr | input | 5 | Low address bits giving the 32-byte alignment offset |
| xfer_size | input | 8 | Transfer size in bytes |
| rfsh_req | input | 1 | Refresh request pulse |
| mem_cs | output | 8 | Chip selects of the current word |
| mem_strobe | output | 20 | Strobe lines of the current word |
| addr_mux | output | 2 | Address-multiplex field of the current word |
| addr_latch | output | 1 | One-cycle pulse on an address-multiplex change |
| xfer_ack | output | 1 | Transfer acknowledge |
| busy | output | 1 | A pattern is running |

## Verification
Several properties are checked on every cycle:
- The outputs stay quiet while idle.
- No acknowledge appears during a software run.
- An address-latch pulse always matches a real change of the multiplex field between two busy cycles.
- A run starts only after a grant.

Other behaviour needs the bench's scenarios:
- Choosing between burst and split transfers, and the number of passes, shown through acknowledge and cycle counts.
- Which entry point is chosen.
- The order in which held requests are served.
- That a store write made while busy has no effect.

// File: rtl/mps_pkg.sv
package mps_pkg;

    localparam int RAM_DEPTH   = 64;
    localparam int RAM_AW      = $clog2(RAM_DEPTH);
    localparam int WORD_W      = 32;
    localparam int CS_W        = 8;
    localparam int STB_W       = 20;
    localparam int AMX_W       = 2;
    localparam int SIZE_W      = 8;
    localparam int ALIGN_BYTES = 32;
    localparam int BEAT_BYTES  = 4;
    localparam int ALIGN_LG    = $clog2(ALIGN_BYTES);
    localparam int BEAT_LG     = $clog2(BEAT_BYTES);
    localparam int CNT_W       = SIZE_W - BEAT_LG + 1;

    typedef struct packed {
        logic             last;
        logic             ack;
        logic [AMX_W-1:0] amux;
        logic [STB_W-1:0] strobe;
        logic [CS_W-1:0]  cs;
    } pat_word_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RFSH = 2'd1,
        SRC_BUS  = 2'd2,
        SRC_SW   = 2'd3
    } src_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic                wr;
        logic                inh;
        logic [ALIGN_LG-1:0] addr;
        logic [SIZE_W-1:0]   size;
    } bus_xfer_t;

    localparam logic [RAM_AW-1:0] ENT_SRD  = RAM_AW'(0);
    localparam logic [RAM_AW-1:0] ENT_SWR  = RAM_AW'(8);
    localparam logic [RAM_AW-1:0] ENT_BRD  = RAM_AW'(16);
    localparam logic [RAM_AW-1:0] ENT_BWR  = RAM_AW'(24);
    localparam logic [RAM_AW-1:0] ENT_RFSH = RAM_AW'(48);

    function automatic logic fits_burst(input bus_xfer_t x);
        return !x.inh && (x.addr == '0) && (x.size != '0) &&
               (x.size[ALIGN_LG-1:0] == '0);
    endfunction

endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram
    import mps_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    parameter int W     = WORD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_allow,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && wr_allow) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mps_req_arbiter.sv
module mps_req_arbiter
    import mps_pkg::*;
#(
    parameter int AW = RAM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rfsh_req,
    input  logic          bus_req,
    input  logic          sw_req,
    input  bus_xfer_t     bus_in,
    input  logic [AW-1:0] sw_start_in,
    input  logic          grant_en,
    output src_t          grant_src,
    output bus_xfer_t     bus_held,
    output logic [AW-1:0] sw_start_held
);

    logic pend_rf_q, pend_bus_q, pend_sw_q;

    always_comb begin
        grant_src = SRC_NONE;
        if (grant_en) begin
            if (pend_rf_q)       grant_src = SRC_RFSH;
            else if (pend_bus_q) grant_src = SRC_BUS;
            else if (pend_sw_q)  grant_src = SRC_SW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_rf_q     <= 1'b0;
            pend_bus_q    <= 1'b0;
            pend_sw_q     <= 1'b0;
            bus_held      <= '0;
            sw_start_held <= '0;
        end else begin
            pend_rf_q  <= (pend_rf_q  && grant_src != SRC_RFSH) || rfsh_req;
            pend_bus_q <= (pend_bus_q && grant_src != SRC_BUS)  || bus_req;
            pend_sw_q  <= (pend_sw_q  && grant_src != SRC_SW)   || sw_req;
            if (bus_req) bus_held      <= bus_in;
            if (sw_req)  sw_start_held <= sw_start_in;
        end
    end

endmodule

// File: rtl/mps_xfer_plan.sv
module mps_xfer_plan
    import mps_pkg::*;
#(
    parameter int AW = RAM_AW,
    parameter int CW = CNT_W
) (
    input  bus_xfer_t     xfer,
    output logic [AW-1:0] entry,
    output logic [CW-1:0] passes
);

    logic              burst;
    logic [SIZE_W:0]   beats_up;

    assign burst    = fits_burst(xfer);
    assign beats_up = ({1'b0, xfer.size} + (SIZE_W+1)'(BEAT_BYTES - 1)) >> BEAT_LG;

    always_comb begin
        if (burst) begin
            entry  = xfer.wr ? ENT_BWR : ENT_BRD;
            passes = CW'(xfer.size >> ALIGN_LG);
        end else begin
            entry  = xfer.wr ? ENT_SWR : ENT_SRD;
            passes = (xfer.size == '0) ? CW'(1) : CW'(beats_up);
        end
    end

endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
    import mps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ram_we,
    input  logic [5:0]        ram_waddr,
    input  logic [31:0]       ram_wdata,
    input  logic [1:0]        mode_op,
    input  logic [5:0]        mode_start,
    input  logic              wr_hit,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic              burst_inh,
    input  logic [4:0]        xfer_addr,
    input  logic [7:0]        xfer_size,
    input  logic              rfsh_req,
    output logic [7:0]        mem_cs,
    output logic [19:0]       mem_strobe,
    output logic [1:0]        addr_mux,
    output logic              addr_latch,
    output logic              xfer_ack,
    output logic              busy
);

    seq_state_t        state_q;
    src_t              src_q;
    src_t              grant_src;
    logic [RAM_AW-1:0] pc_q, entry_q, sw_start_held, plan_entry;
    logic [CNT_W-1:0]  passes_q, plan_passes;
    logic [AMX_W-1:0]  prev_amux_q;
    logic              first_q;
    logic [WORD_W-1:0] rd_raw;
    pat_word_t         word;
    bus_xfer_t         bus_in, bus_held;
    logic              running;

    assign running = (state_q == ST_RUN);
    assign bus_in  = '{wr: bus_wr, inh: burst_inh, addr: xfer_addr, size: xfer_size};

    mps_pattern_ram u_ram (
        .clk      (clk),
        .we       (ram_we),
        .wr_allow (!running),
        .waddr    (ram_waddr),
        .wdata    (ram_wdata),
        .raddr    (pc_q),
        .rdata    (rd_raw)
    );

    mps_req_arbiter u_arb (
        .clk           (clk),
        .rst           (rst),
        .rfsh_req      (rfsh_req),
        .bus_req       (bus_req),
        .sw_req        (wr_hit && mode_op == 2'b11),
        .bus_in        (bus_in),
        .sw_start_in   (mode_start),
        .grant_en      (!running),
        .grant_src     (grant_src),
        .bus_held      (bus_held),
        .sw_start_held (sw_start_held)
    );

    mps_xfer_plan u_plan (
        .xfer   (bus_held),
        .entry  (plan_entry),
        .passes (plan_passes)
    );

    assign word = pat_word_t'(rd_raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            src_q       <= SRC_NONE;
            pc_q        <= '0;
            entry_q     <= '0;
            passes_q    <= '0;
            prev_amux_q <= '0;
            first_q     <= 1'b0;
        end else if (!running) begin
            first_q <= 1'b1;
            if (grant_src != SRC_NONE) begin
                state_q <= ST_RUN;
                src_q   <= grant_src;
                unique case (grant_src)
                    SRC_RFSH: begin pc_q <= ENT_RFSH;      entry_q <= ENT_RFSH;      passes_q <= CNT_W'(1); end
                    SRC_BUS:  begin pc_q <= plan_entry;    entry_q <= plan_entry;    passes_q <= plan_passes; end
                    default:  begin pc_q <= sw_start_held; entry_q <= sw_start_held; passes_q <= CNT_W'(1); end
                endcase
            end
        end else begin
            prev_amux_q <= word.amux;
            if (word.last) begin
                first_q <= 1'b1;
                if (passes_q > CNT_W'(1)) begin
                    passes_q <= passes_q - CNT_W'(1);
                    pc_q     <= entry_q;
                end else begin
                    state_q <= ST_IDLE;
                    src_q   <= SRC_NONE;
                end
            end else begin
                first_q <= 1'b0;
                pc_q    <= pc_q + RAM_AW'(1);
            end
        end
    end

    assign busy       = running;
    assign mem_cs     = running ? word.cs     : '0;
    assign mem_strobe = running ? word.strobe : '0;
    assign addr_mux   = running ? word.amux   : '0;
    assign addr_latch = running && !first_q && (word.amux != prev_amux_q);
    assign xfer_ack   = running && word.ack && (src_q == SRC_BUS);

endmodule

// File: rtl/mps_checker.sv
module mps_checker
    import mps_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        xfer_ack,
    input logic        addr_latch,
    input logic [7:0]  mem_cs,
    input logic [19:0] mem_strobe,
    input logic [1:0]  addr_mux,
    input src_t        src_q,
    input src_t        grant_src
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_cs == '0 && mem_strobe == '0 && !xfer_ack && !addr_latch));

    // R8
    sw_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && src_q == SRC_SW) |-> !xfer_ack);

    // R10
    latch_change_chk: assert property (@(posedge clk) disable iff (rst)
        addr_latch |-> (busy && $past(busy) && addr_mux != $past(addr_mux)));

    // R9
    start_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(grant_src != SRC_NONE));

    // R8
    ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> busy);

endmodule

bind pattern_sequencer mps_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .xfer_ack   (xfer_ack),
    .addr_latch (addr_latch),
    .mem_cs     (mem_cs),
    .mem_strobe (mem_strobe),
    .addr_mux   (addr_mux),
    .src_q      (src_q),
    .grant_src  (grant_src)
);

// File: tb/sim_pattern_sequencer.sv
module sim_pattern_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ram_we = 1'b0;
    logic [5:0]  ram_waddr = '0;
    logic [31:0] ram_wdata = '0;
    logic [1:0]  mode_op = '0;
    logic [5:0]  mode_start = '0;
    logic        wr_hit = 1'b0, bus_req = 1'b0, bus_wr = 1'b0, burst_inh = 1'b0, rfsh_req = 1'b0;
    logic [4:0]  xfer_addr = '0;
    logic [7:0]  xfer_size = '0;
    logic [7:0]  mem_cs;
    logic [19:0] mem_strobe;
    logic [1:0]  addr_mux;
    logic        addr_latch, xfer_ack, busy;

    always #2 clk = ~clk;

    pattern_sequencer u0 (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    int busy_cyc, ack_cnt, ale_cnt, runs;
    logic [7:0] log_cs [8];
    logic prev_busy = 1'b0;

    // {wr, inh, addr[4:0], size[7:0], acks[7:0], cycles[7:0], first cs[7:0]}
    localparam logic [38:0] VEC [8] = '{
        {1'b0, 1'b0, 5'd0, 8'd4,  8'd1,  8'd2,  8'h01},
        {1'b1, 1'b0, 5'd0, 8'd4,  8'd1,  8'd3,  8'h02},
        {1'b0, 1'b0, 5'd0, 8'd32, 8'd4,  8'd4,  8'h04},
        {1'b1, 1'b0, 5'd0, 8'd64, 8'd8,  8'd8,  8'h08},
        {1'b0, 1'b1, 5'd0, 8'd32, 8'd8,  8'd16, 8'h01},
        {1'b0, 1'b0, 5'd4, 8'd32, 8'd8,  8'd16, 8'h01},
        {1'b1, 1'b0, 5'd0, 8'd40, 8'd10, 8'd30, 8'h02},
        {1'b0, 1'b0, 5'd0, 8'd6,  8'd2,  8'd4,  8'h01}
    };

    always @(negedge clk) begin
        if (busy) begin
            busy_cyc++;
            if (!prev_busy && runs < 8) begin
                log_cs[runs] = mem_cs;
                runs++;
            end
        end
        if (xfer_ack)   ack_cnt++;
        if (addr_latch) ale_cnt++;
        prev_busy = busy;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        busy_cyc = 0; ack_cnt = 0; ale_cnt = 0; runs = 0;
        for (int i = 0; i < 8; i++) log_cs[i] = '0;
    endtask

    task automatic put_word(input int a, input bit last, input bit ack, input int amx, input int cs);
        @(negedge clk);
        ram_we    = 1'b1;
        ram_waddr = 6'(a);
        ram_wdata = {last, ack, 2'(amx), 20'(a + 1), 8'(cs)};
        @(negedge clk);
        ram_we    = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int guard = 0;
        while (quiet < 4 && guard < 500) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
            guard++;
        end
    endtask

    task automatic pulse_bus(input bit wr, input bit inh, input logic [4:0] ad, input logic [7:0] sz);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; burst_inh = inh; xfer_addr = ad; xfer_size = sz;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic pulse_sw(input logic [1:0] op, input logic [5:0] st);
        @(negedge clk);
        wr_hit = 1'b1; mode_op = op; mode_start = st;
        @(negedge clk);
        wr_hit = 1'b0;
    endtask

    task automatic pulse_rf();
        @(negedge clk);
        rfsh_req = 1'b1;
        @(negedge clk);
        rfsh_req = 1'b0;
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && mem_cs == 0 && mem_strobe == 0 && addr_mux == 0 && !addr_latch && !xfer_ack,
            "R1", int'(busy), 0);

        put_word(0, 0, 0, 0, 8'h01);  put_word(1, 1, 1, 0, 8'h01);
        put_word(8, 0, 0, 0, 8'h02);  put_word(9, 0, 0, 0, 8'h02);  put_word(10, 1, 1, 0, 8'h02);
        for (int i = 16; i < 20; i++) put_word(i, i == 19, 1, 0, 8'h04);
        for (int i = 24; i < 28; i++) put_word(i, i == 27, 1, 0, 8'h08);
        put_word(40, 0, 1, 0, 8'h03); put_word(41, 0, 1, 1, 8'h03); put_word(42, 1, 1, 2, 8'h03);
        put_word(48, 0, 0, 0, 8'hFF); put_word(49, 1, 0, 0, 8'hFF);

        // R3 R4 R5 R6 R2 R8: bus transfer table
        for (int v = 0; v < 8; v++) begin
            string tag;
            logic [38:0] e;
            e = VEC[v];
            tag = (v < 2) ? "R3" : (v < 4) ? "R4" : (v == 4) ? "R5" : "R6";
            clr_mon();
            pulse_bus(e[38], e[37], e[36:32], e[31:24]);
            wait_idle();
            chk(ack_cnt == int'(e[23:16]), {tag, " R8 acks"}, ack_cnt, int'(e[23:16]));
            chk(busy_cyc == int'(e[15:8]), {tag, " R2 cycles"}, busy_cyc, int'(e[15:8]));
            chk(log_cs[0] == e[7:0], {tag, " entry cs"}, int'(log_cs[0]), int'(e[7:0]));
        end

        // R2 first word appears two cycles after the sampling edge
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; burst_inh = 1'b0; xfer_addr = '0; xfer_size = 8'd4;
        @(negedge clk);
        bus_req = 1'b0;
        chk(!busy, "R2 latency early", int'(busy), 0);
        @(negedge clk);
        chk(busy && mem_cs == 8'h01 && mem_strobe == 20'd1, "R2 latency first word", int'(mem_strobe), 1);
        wait_idle();

        // R7 R8 R10 software run
        clr_mon();
        pulse_sw(2'b11, 6'd40);
        wait_idle();
        chk(runs == 1 && log_cs[0] == 8'h03, "R7 sw entry", int'(log_cs[0]), 3);
        chk(busy_cyc == 3, "R7 sw cycles", busy_cyc, 3);
        chk(ack_cnt == 0, "R8 sw no ack", ack_cnt, 0);
        chk(ale_cnt == 2, "R10 latch pulses", ale_cnt, 2);

        // R7 other opcode ignored
        clr_mon();
        pulse_sw(2'b10, 6'd40);
        wait_idle();
        chk(runs == 0, "R7 wrong opcode", runs, 0);

        // R3 R8 refresh
        clr_mon();
        pulse_rf();
        wait_idle();
        chk(log_cs[0] == 8'hFF && busy_cyc == 2, "R3 refresh entry", int'(log_cs[0]), 255);
        chk(ack_cnt == 0, "R8 refresh no ack", ack_cnt, 0);

        // R9 priority with simultaneous requests
        clr_mon();
        @(negedge clk);
        rfsh_req = 1'b1; bus_req = 1'b1; bus_wr = 1'b0; burst_inh = 1'b0; xfer_addr = '0; xfer_size = 8'd4;
        wr_hit = 1'b1; mode_op = 2'b11; mode_start = 6'd40;
        @(negedge clk);
        rfsh_req = 1'b0; bus_req = 1'b0; wr_hit = 1'b0;
        wait_idle();
        chk(runs == 3, "R9 runs served", runs, 3);
        chk(log_cs[0] == 8'hFF && log_cs[1] == 8'h01 && log_cs[2] == 8'h03, "R9 order",
            int'(log_cs[1]), 1);
        chk(ack_cnt == 1, "R9 acks", ack_cnt, 1);

        // R11 write while busy is dropped
        pulse_rf();
        while (!busy) @(negedge clk);
        ram_we = 1'b1; ram_waddr = 6'd48; ram_wdata = {1'b0, 1'b0, 2'd0, 20'd0, 8'hAA};
        @(negedge clk);
        ram_we = 1'b0;
        wait_idle();
        clr_mon();
        pulse_rf();
        wait_idle();
        chk(log_cs[0] == 8'hFF, "R11 busy write dropped", int'(log_cs[0]), 255);

        finish_sim();
    end

endmodule